// File: doc/BRIEF.md
# AXI4-to-AXI3 Write ID Regenerator

This block joins a write master whose data channel carries no ID to a downstream AXI3 slave port that needs a write-data ID on every beat. Each accepted write address pushes its ID into an in-order queue. Write bursts must follow their addresses in the same order, and interleaving is not allowed. The oldest queued ID is then driven as the write-data ID on every beat of the current burst. The entry is retired on the beat that carries the last-beat flag, so the next burst takes the next ID.

A parameter picks the source of the write-data ID. The default source is the internal queue. In that mode the ID can also be written into a chosen bit field of the user sideband. The other source is a user sideband field that the master fills at the same bit positions. In that mode the queue only counts bursts, and no ID storage is built.

The upstream lock is a single bit, following AXI4. It is widened to the two-bit AXI3 encoding, which never marks a locked access. The address and data channels are combinational pass-through paths. They are gated only when the queue is full or empty.

Top module: `axi_wid_regen`

## Requirements
- R1: With the queue not full and out of reset, m_awvalid_o equals s_awvalid_i and s_awready_o equals m_awready_i. The address ID, address and length pass through unchanged in the same cycle.
- R2: On every forwarded data beat, m_wid_o equals the ID of the oldest address accepted and not yet retired. The value stays the same on all beats of one burst.
- R3: With DEPTH bursts outstanding, s_awready_o and m_awvalid_o are low, and no further address is accepted.
- R4: With no burst outstanding, m_wvalid_o and s_wready_o are low. Data that arrives before its address is held upstream.
- R5: An entry is retired only on a data handshake with s_wlast_i high, and a beat without that flag keeps it. An accept and a retire in the same cycle leave the occupancy unchanged.
- R6: m_awlock_o is 2'b01 when s_awlock_i is 1 and 2'b00 when it is 0. The value 2'b10 never appears.
- R7: In queue mode with ID insertion on, m_wuser_o bits [USER_OFS +: ID_W] carry the queued ID. All other m_wuser_o bits equal s_wuser_i.
- R8: In sideband mode, m_wid_o equals s_wuser_i[USER_OFS +: ID_W] and m_wuser_o equals s_wuser_i. Data gating by occupancy is the same as in queue mode.
- R9: While rst_ni is low, all four valid and ready outputs are low, whatever the inputs are. After reset the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| s_awid_i | input | ID_W | Upstream address ID |
| s_awaddr_i | input | ADDR_W | Upstream address |
| s_awlen_i | input | LEN_W | Upstream burst length minus one |
| s_awlock_i | input | 1 | Upstream exclusive flag |
| s_awvalid_i | input | 1 | Upstream address valid |
| s_awready_o | output | 1 | Upstream address ready |
| m_awid_o | output | ID_W | Downstream address ID |
| m_awaddr_o | output | ADDR_W | Downstream address |
| m_awlen_o | output | LEN_W | Downstream burst length minus one |
| m_awlock_o | output | 2 | Downstream two-bit lock code |
| m_awvalid_o | output | 1 | Downstream address valid |
| m_awready_i | input | 1 | Downstream address ready |
| s_wdata_i | input | DATA_W | Upstream write data |
| s_wstrb_i | input | DATA_W/8 | Upstream byte strobes |
| s_wlast_i | input | 1 | Upstream last beat of burst |
| s_wuser_i | input | USER_W | Upstream user sideband |
| s_wvalid_i | input | 1 | Upstream data valid |
| s_wready_o | output | 1 | Upstream data ready |
| m_wid_o | output | ID_W | Regenerated write-data ID |
| m_wdata_o | output | DATA_W | Downstream write data |
| m_wstrb_o | output | DATA_W/8 | Downstream byte strobes |
| m_wlast_o | output | 1 | Downstream last beat |
| m_wuser_o | output | USER_W | Downstream user sideband |
| m_wvalid_o | output | 1 | Downstream data valid |
| m_wready_i | input | 1 | Downstream data ready |

## Verification
The bench first sends data with no address queued, which tests the empty gating. It then sends a run of addresses with the data channel idle, which fills the queue to its limit and tests the full gating. A drain phase follows, then continuous traffic on both channels, where accepts and retires often fall in the same cycle. Last come long random phases with mixed burst lengths and backpressure on both sides. These phases separate a queue that retires on every beat from one that retires only on the last beat, and show whether the ID moves on too early or too late. A second instance in sideband mode gets a sideband that holds the right ID, while the queue-mode instance gets an unrelated field. This shows which source each instance really uses.

// File: rtl/axi_wid_regen_pkg.sv
`timescale 1ns/1ps
package axi_wid_regen_pkg;
  typedef enum logic [1:0] {
    LOCK_NORMAL = 2'b00,
    LOCK_EXCL   = 2'b01,
    LOCK_HELD   = 2'b10
  } axi3_lock_e;

  function automatic axi3_lock_e to_axi3_lock(input logic excl);
    return excl ? LOCK_EXCL : LOCK_NORMAL;
  endfunction
endpackage

// File: rtl/wid_queue.sv
`timescale 1ns/1ps
module wid_queue #(
  parameter int ID_W  = 4,
  parameter int DEPTH = 8,
  parameter bit STORE = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [ID_W-1:0] id_i,
  input  logic            pop_i,
  output logic [ID_W-1:0] head_o,
  output logic            full_o,
  output logic            empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt <= '0;
    else begin
      case ({push_i, pop_i})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: ;
      endcase
    end
  end

  assign full_o  = (cnt == CNT_W'(DEPTH));
  assign empty_o = (cnt == '0);

  generate
    if (STORE) begin : g_store
      logic [ID_W-1:0]  mem [DEPTH];
      logic [PTR_W-1:0] wp, rp;

      function automatic logic [PTR_W-1:0] inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
      endfunction

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          wp <= '0;
          rp <= '0;
        end else begin
          if (push_i) wp <= inc(wp);
          if (pop_i)  rp <= inc(rp);
        end
      end

      always_ff @(posedge clk_i) begin
        if (push_i) mem[wp] <= id_i;
      end

      assign head_o = mem[rp];
    end else begin : g_count
      logic unused_id;
      assign unused_id = ^id_i;
      assign head_o    = '0;
    end
  endgenerate

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o); // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o); // R4
  AST_PUSH_POP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && pop_i) |=> $stable(cnt)); // R5
endmodule

// File: rtl/aw_lock_map.sv
`timescale 1ns/1ps
module aw_lock_map
  import axi_wid_regen_pkg::*;
(
  input  logic       excl_i,
  output logic [1:0] lock_o
);
  assign lock_o = to_axi3_lock(excl_i);
endmodule

// File: rtl/w_id_sel.sv
`timescale 1ns/1ps
module w_id_sel #(
  parameter int ID_W          = 4,
  parameter int USER_W        = 8,
  parameter int USER_OFS      = 0,
  parameter bit WID_FROM_USER = 1'b0,
  parameter bit ID_TO_USER    = 1'b1
) (
  input  logic [ID_W-1:0]   head_i,
  input  logic [USER_W-1:0] user_i,
  output logic [ID_W-1:0]   wid_o,
  output logic [USER_W-1:0] user_o
);
  generate
    if (WID_FROM_USER) begin : g_user_src
      logic unused_head;
      assign unused_head = ^head_i;
      assign wid_o       = user_i[USER_OFS +: ID_W];
      assign user_o      = user_i;
    end else begin : g_queue_src
      assign wid_o = head_i;
      if (ID_TO_USER) begin : g_ins
        always_comb begin
          user_o = user_i;
          user_o[USER_OFS +: ID_W] = head_i;
        end
      end else begin : g_pass
        assign user_o = user_i;
      end
    end
  endgenerate
endmodule

// File: rtl/axi_wid_regen.sv
`timescale 1ns/1ps
module axi_wid_regen #(
  parameter int ID_W          = 4,
  parameter int ADDR_W        = 32,
  parameter int LEN_W         = 8,
  parameter int DATA_W        = 32,
  parameter int USER_W        = 8,
  parameter int DEPTH         = 8,
  parameter int USER_OFS      = 2,
  parameter bit WID_FROM_USER = 1'b0,
  parameter bit ID_TO_USER    = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ID_W-1:0]     s_awid_i,
  input  logic [ADDR_W-1:0]   s_awaddr_i,
  input  logic [LEN_W-1:0]    s_awlen_i,
  input  logic                s_awlock_i,
  input  logic                s_awvalid_i,
  output logic                s_awready_o,
  output logic [ID_W-1:0]     m_awid_o,
  output logic [ADDR_W-1:0]   m_awaddr_o,
  output logic [LEN_W-1:0]    m_awlen_o,
  output logic [1:0]          m_awlock_o,
  output logic                m_awvalid_o,
  input  logic                m_awready_i,
  input  logic [DATA_W-1:0]   s_wdata_i,
  input  logic [DATA_W/8-1:0] s_wstrb_i,
  input  logic                s_wlast_i,
  input  logic [USER_W-1:0]   s_wuser_i,
  input  logic                s_wvalid_i,
  output logic                s_wready_o,
  output logic [ID_W-1:0]     m_wid_o,
  output logic [DATA_W-1:0]   m_wdata_o,
  output logic [DATA_W/8-1:0] m_wstrb_o,
  output logic                m_wlast_o,
  output logic [USER_W-1:0]   m_wuser_o,
  output logic                m_wvalid_o,
  input  logic                m_wready_i
);
  logic            full, empty, push, pop;
  logic [ID_W-1:0] head_id;

  // address channel: gated only by queue space
  assign m_awvalid_o = rst_ni & s_awvalid_i & ~full;
  assign s_awready_o = rst_ni & m_awready_i & ~full;
  assign m_awid_o    = s_awid_i;
  assign m_awaddr_o  = s_awaddr_i;
  assign m_awlen_o   = s_awlen_i;
  assign push        = s_awvalid_i & s_awready_o;

  aw_lock_map u_lock (
    .excl_i (s_awlock_i),
    .lock_o (m_awlock_o)
  );

  // data channel: held until its address has been accepted
  assign m_wvalid_o = s_wvalid_i & ~empty;
  assign s_wready_o = m_wready_i & ~empty;
  assign m_wdata_o  = s_wdata_i;
  assign m_wstrb_o  = s_wstrb_i;
  assign m_wlast_o  = s_wlast_i;
  assign pop        = s_wvalid_i & s_wready_o & s_wlast_i;

  wid_queue #(
    .ID_W  (ID_W),
    .DEPTH (DEPTH),
    .STORE (!WID_FROM_USER)
  ) u_queue (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .id_i    (s_awid_i),
    .pop_i   (pop),
    .head_o  (head_id),
    .full_o  (full),
    .empty_o (empty)
  );

  w_id_sel #(
    .ID_W          (ID_W),
    .USER_W        (USER_W),
    .USER_OFS      (USER_OFS),
    .WID_FROM_USER (WID_FROM_USER),
    .ID_TO_USER    (ID_TO_USER)
  ) u_sel (
    .head_i (head_id),
    .user_i (s_wuser_i),
    .wid_o  (m_wid_o),
    .user_o (m_wuser_o)
  );

  AST_LOCK_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_awvalid_o |-> (m_awlock_o == {1'b0, s_awlock_i})); // R6
  AST_AW_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_awvalid_o && m_awready_i) |-> s_awready_o); // R1

  generate
    if (!WID_FROM_USER) begin : g_wid_chk
      AST_WID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (m_wvalid_o && m_wready_i && !s_wlast_i) |=> (m_wid_o == $past(m_wid_o))); // R2
    end
  endgenerate
endmodule

// File: tb/tb_axi_wid_regen.sv
`timescale 1ns/1ps
module tb_axi_wid_regen;
  localparam int ID_W = 4, ADDR_W = 32, LEN_W = 8, DATA_W = 32, USER_W = 8;
  localparam int DEPTH = 8, UOFS = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [ID_W-1:0] s_awid; logic [ADDR_W-1:0] s_awaddr; logic [LEN_W-1:0] s_awlen;
  logic s_awlock, s_awvalid, m_awready;
  logic [DATA_W-1:0] s_wdata; logic [DATA_W/8-1:0] s_wstrb;
  logic s_wlast, s_wvalid, m_wready;
  logic [USER_W-1:0] s_wuser_a, s_wuser_b;

  logic s_awready, m_awvalid, s_wready, m_wvalid, m_wlast;
  logic [ID_W-1:0] m_awid, m_wid; logic [ADDR_W-1:0] m_awaddr; logic [LEN_W-1:0] m_awlen;
  logic [1:0] m_awlock; logic [DATA_W-1:0] m_wdata; logic [DATA_W/8-1:0] m_wstrb;
  logic [USER_W-1:0] m_wuser;

  logic u_awready, u_awvalid, u_wready, u_wvalid, u_wlast;
  logic [ID_W-1:0] u_awid, u_wid; logic [ADDR_W-1:0] u_awaddr; logic [LEN_W-1:0] u_awlen;
  logic [1:0] u_awlock; logic [DATA_W-1:0] u_wdata; logic [DATA_W/8-1:0] u_wstrb;
  logic [USER_W-1:0] u_wuser;

  axi_wid_regen #(.ID_W(ID_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W),
    .USER_W(USER_W), .DEPTH(DEPTH), .USER_OFS(UOFS), .WID_FROM_USER(1'b0),
    .ID_TO_USER(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .s_awid_i(s_awid), .s_awaddr_i(s_awaddr), .s_awlen_i(s_awlen), .s_awlock_i(s_awlock),
    .s_awvalid_i(s_awvalid), .s_awready_o(s_awready),
    .m_awid_o(m_awid), .m_awaddr_o(m_awaddr), .m_awlen_o(m_awlen), .m_awlock_o(m_awlock),
    .m_awvalid_o(m_awvalid), .m_awready_i(m_awready),
    .s_wdata_i(s_wdata), .s_wstrb_i(s_wstrb), .s_wlast_i(s_wlast), .s_wuser_i(s_wuser_a),
    .s_wvalid_i(s_wvalid), .s_wready_o(s_wready),
    .m_wid_o(m_wid), .m_wdata_o(m_wdata), .m_wstrb_o(m_wstrb), .m_wlast_o(m_wlast),
    .m_wuser_o(m_wuser), .m_wvalid_o(m_wvalid), .m_wready_i(m_wready));

  axi_wid_regen #(.ID_W(ID_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W),
    .USER_W(USER_W), .DEPTH(DEPTH), .USER_OFS(UOFS), .WID_FROM_USER(1'b1),
    .ID_TO_USER(1'b0)) dut_usr (
    .clk_i(clk), .rst_ni(rst_ni),
    .s_awid_i(s_awid), .s_awaddr_i(s_awaddr), .s_awlen_i(s_awlen), .s_awlock_i(s_awlock),
    .s_awvalid_i(s_awvalid), .s_awready_o(u_awready),
    .m_awid_o(u_awid), .m_awaddr_o(u_awaddr), .m_awlen_o(u_awlen), .m_awlock_o(u_awlock),
    .m_awvalid_o(u_awvalid), .m_awready_i(m_awready),
    .s_wdata_i(s_wdata), .s_wstrb_i(s_wstrb), .s_wlast_i(s_wlast), .s_wuser_i(s_wuser_b),
    .s_wvalid_i(s_wvalid), .s_wready_o(u_wready),
    .m_wid_o(u_wid), .m_wdata_o(u_wdata), .m_wstrb_o(u_wstrb), .m_wlast_o(u_wlast),
    .m_wuser_o(u_wuser), .m_wvalid_o(u_wvalid), .m_wready_i(m_wready));

  typedef struct { logic [ID_W-1:0] id; int len; } ent_t;
  ent_t q[$];
  int bcnt = 0;
  int total = 0, bad = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h t=%0t", tag, got, exp, $time);
    end
  endtask

  function automatic bit roll(input int pct);
    return $urandom_range(99) < pct;
  endfunction

  task automatic cycle(input int paw, input int pw, input int pawr, input int pwr);
    bit exp_awok, exp_wok, hs_aw, hs_w;
    logic [USER_W-1:0] eu;
    @(negedge clk);
    s_awvalid = roll(paw);
    s_awid    = ID_W'($urandom);
    s_awaddr  = $urandom;
    s_awlen   = LEN_W'($urandom_range(3));
    s_awlock  = 1'($urandom);
    m_awready = roll(pawr);
    s_wvalid  = roll(pw);
    m_wready  = roll(pwr);
    s_wdata   = $urandom;
    s_wstrb   = 4'($urandom);
    s_wuser_a = USER_W'($urandom);
    s_wuser_b = USER_W'($urandom);
    if (q.size() > 0) begin
      s_wlast = (bcnt == q[0].len);
      s_wuser_b[UOFS +: ID_W] = q[0].id;
    end else s_wlast = 1'($urandom);
    #1;
    exp_awok = (q.size() < DEPTH);
    exp_wok  = (q.size() > 0);
    chk("R1/R3 m_awvalid", 32'(m_awvalid), 32'(s_awvalid && exp_awok));
    chk("R1/R3 s_awready", 32'(s_awready), 32'(m_awready && exp_awok));
    chk("R1 m_awid", 32'(m_awid), 32'(s_awid));
    chk("R1 m_awaddr", m_awaddr, s_awaddr);
    chk("R1 m_awlen", 32'(m_awlen), 32'(s_awlen));
    chk("R6 m_awlock", 32'(m_awlock), {31'd0, s_awlock});
    chk("R4 m_wvalid", 32'(m_wvalid), 32'(s_wvalid && exp_wok));
    chk("R4 s_wready", 32'(s_wready), 32'(m_wready && exp_wok));
    chk("R5 m_wlast", 32'(m_wlast), 32'(s_wlast));
    chk("R1 m_wdata", m_wdata, s_wdata);
    if (exp_wok) begin
      chk("R2 m_wid", 32'(m_wid), 32'(q[0].id));
      eu = s_wuser_a; eu[UOFS +: ID_W] = q[0].id;
      chk("R7 m_wuser", 32'(m_wuser), 32'(eu));
    end
    chk("R8 usr m_wid", 32'(u_wid), 32'(s_wuser_b[UOFS +: ID_W]));
    chk("R8 usr m_wuser", 32'(u_wuser), 32'(s_wuser_b));
    chk("R8 usr m_wvalid", 32'(u_wvalid), 32'(s_wvalid && exp_wok));
    chk("R8 usr s_awready", 32'(u_awready), 32'(m_awready && exp_awok));
    hs_aw = s_awvalid && exp_awok && m_awready;
    hs_w  = s_wvalid && exp_wok && m_wready;
    if (hs_w) begin
      if (s_wlast) begin void'(q.pop_front()); bcnt = 0; end
      else bcnt++;
    end
    if (hs_aw) q.push_back('{id: s_awid, len: int'(s_awlen)});
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    s_awvalid = 1'b1; s_wvalid = 1'b1; m_awready = 1'b1; m_wready = 1'b1;
    s_awid = '0; s_awaddr = '0; s_awlen = '0; s_awlock = 1'b0;
    s_wdata = '0; s_wstrb = '0; s_wlast = 1'b1; s_wuser_a = '0; s_wuser_b = '0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      chk("R9 rst m_awvalid", 32'(m_awvalid), 32'd0);
      chk("R9 rst s_awready", 32'(s_awready), 32'd0);
      chk("R9 rst m_wvalid", 32'(m_wvalid), 32'd0);
      chk("R9 rst s_wready", 32'(s_wready), 32'd0);
    end
    @(negedge clk); rst_ni = 1'b1; s_awvalid = 1'b0; s_wvalid = 1'b0;
    // R4: data ahead of any address
    for (int i = 0; i < 6; i++) cycle(0, 100, 100, 100);
    // R3: fill to the limit with data idle
    for (int i = 0; i < 14; i++) cycle(100, 0, 100, 100);
    // R5: drain bursts beat by beat
    for (int i = 0; i < 60; i++) cycle(0, 100, 100, 100);
    // R5: concurrent accept and retire
    for (int i = 0; i < 300; i++) cycle(100, 100, 100, 100);
    // mixed backpressure
    for (int i = 0; i < 1500; i++) cycle(60, 70, 50, 60);
    for (int i = 0; i < 1500; i++) cycle(90, 40, 90, 30);
    for (int i = 0; i < 1500; i++) cycle(30, 90, 40, 90);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule